// File: doc/BRIEF.md
# Buck Regulator Start-Up and Protection Sequencer

This block is the digital sequencer of a synchronous step-down regulator. It brings the converter from an unpowered state to regulation and reacts to the protection comparators. When the supply-good and enable comparators are both high, it first runs a short phase that samples the over-current threshold. It then ramps a reference code from zero to full scale in a fixed number of even steps, paced by the switching-oscillator tick. After that it regulates until a fault or a shutdown request arrives.

All comparator results arrive as asynchronous levels and are synchronized in the block. The oscillator tick is a single-cycle strobe that is already synchronous to the clock. The outputs are plain levels: the reference code for the DAC, a sample strobe for the threshold hold circuit, a switching enable, a forced-low-side request and a latched-fault flag. The block has no streaming data path, so it has no valid/ready handshake. Every pin is a level that is valid in each cycle.

The block handles faults as follows. An over-current event restarts the ramp once, and a second over-current event shuts the converter down and latches it. A feedback under-voltage also latches a shutdown. A feedback over-voltage only clamps: the low side is held on until the comparator clears. The latch is cleared only when supply-good drops or when the enable comparator is pulled low and released.

Top module: `ssf_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all outputs are low and `ref_code` is 0.
- R2: Once supply-good and enable are both high, the block spends exactly OCSET_TICKS oscillator ticks with `oc_sample` high and every other output low.
- R3: Soft-start then runs for exactly RAMP_TICKS ticks. After k ticks, `ref_code` equals floor(STEPS*k/RAMP_TICKS). It never moves by more than one code per tick, and it holds its value in any cycle without a tick. When the ramp ends, `ref_code` reads STEPS.
- R4: `conv_en` is high during soft-start and regulation, and low in every other state.
- R5: The first rising over-current event in soft-start, regulation or clamp restarts soft-start from code 0. The threshold is not sampled again, so `oc_sample` stays low.
- R6: A second rising over-current event latches shutdown: `fault_latched`=1, `conv_en`=0, `ref_code`=0. Further comparator activity does not release it.
- R7: An under-voltage during regulation latches shutdown. Under-voltage and over-voltage are ignored during soft-start.
- R8: An over-voltage during regulation sets `force_low`=1 and `conv_en`=0, and holds `ref_code` at STEPS. Regulation resumes when the comparator clears.
- R9: Loss of supply-good or enable, from any state, returns the block to idle. This clears the latch and the over-current count. The next start runs the threshold phase again.
- R10: Every comparator input acts on the outputs at the third rising clock edge after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| supply_ok_a | input | 1 | Supply-good comparator (asynchronous) |
| comp_en_a | input | 1 | Error-amplifier output above shutdown level (asynchronous) |
| fb_uv_a | input | 1 | Feedback below half of reference (asynchronous) |
| fb_ov_a | input | 1 | Feedback over-voltage comparator with hysteresis (asynchronous) |
| oc_trip_a | input | 1 | Low-side drop above twice the held threshold (asynchronous) |
| ref_code | output | CODE_W | Soft-start reference code, 0 to STEPS |
| oc_sample | output | 1 | Sample strobe for the over-current threshold |
| conv_en | output | 1 | Normal PWM switching allowed |
| fault_latched | output | 1 | Latched shutdown |
| force_low | output | 1 | Over-voltage clamp: high side off, low side on |

## Verification
A comparator change reaches the outputs at the third rising edge after it. Two edges go to the synchronizer and one to the state register. The checks therefore drive inputs on a falling edge, step a counted number of rising edges, and sample on the next falling edge. A directed test confirms that the output has not moved after two edges and has moved after three. Ramp and threshold phases advance only on ticks, and the tick is held high except in the freeze test, so phase lengths are known in clock cycles. The table rows wait long enough to land inside a stable state. The ramp test samples every cycle and compares each code with the floor formula at its tick index.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_OCSET   = 3'd1,
    ST_SOFT    = 3'd2,
    ST_RUN     = 3'd3,
    ST_OVCLAMP = 3'd4,
    ST_LATCH   = 3'd5
  } seq_state_t;
endpackage

// File: rtl/ssf_sync.sv
module ssf_sync #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta, stable;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta   <= 1'b0;
        stable <= 1'b0;
      end else begin
        meta   <= din[g];
        stable <= meta;
      end
    end
    assign dout[g] = stable;
  end
endmodule

// File: rtl/ssf_tick_timer.sv
module ssf_tick_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic done
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign done = adv && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (adv)    cnt <= done ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/ssf_ramp.sv
module ssf_ramp #(
  parameter int STEPS = 40,
  parameter int SPAN  = 512,
  localparam int CODE_W = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [CODE_W-1:0] step,
  output logic              last
);
  localparam int ACC_W = $clog2(SPAN + STEPS + 1);
  localparam logic [ACC_W-1:0]  INC     = ACC_W'(STEPS);
  localparam logic [ACC_W-1:0]  SPAN_V  = ACC_W'(SPAN);
  localparam logic [CODE_W-1:0] TOP_M1  = CODE_W'(STEPS - 1);
  localparam logic [CODE_W-1:0] TOP     = CODE_W'(STEPS);

  logic [ACC_W-1:0] acc, sum;
  logic             wrap;

  assign sum  = acc + INC;
  assign wrap = (sum >= SPAN_V);
  assign last = adv && wrap && (step == TOP_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      step <= '0;
    end else if (clr) begin
      acc  <= '0;
      step <= '0;
    end else if (adv) begin
      acc <= wrap ? (sum - SPAN_V) : sum;
      if (wrap) step <= step + 1'b1;
    end
  end

  // R3: code only moves on a tick
  a_r3_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(step));
  // R3: code never exceeds full scale
  a_r3_code_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    step <= TOP);
endmodule

// File: rtl/ssf_sequencer.sv
module ssf_sequencer #(
  parameter int STEPS       = 40,
  parameter int RAMP_TICKS  = 512,
  parameter int OCSET_TICKS = 64,
  localparam int CODE_W = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              supply_ok_a,
  input  logic              comp_en_a,
  input  logic              fb_uv_a,
  input  logic              fb_ov_a,
  input  logic              oc_trip_a,
  output logic [CODE_W-1:0] ref_code,
  output logic              oc_sample,
  output logic              conv_en,
  output logic              fault_latched,
  output logic              force_low
);
  import ssf_pkg::*;

  localparam logic [CODE_W-1:0] FULL = CODE_W'(STEPS);

  logic sup_s, cmp_s, uv_s, ov_s, oc_s;
  logic oc_prev, oc_evt;
  logic oc_seen, oc_seen_nx;
  logic restart;
  logic timer_done, ramp_last;
  logic [CODE_W-1:0] step;
  seq_state_t st, st_nx;

  ssf_sync #(.WIDTH(5)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({supply_ok_a, comp_en_a, fb_uv_a, fb_ov_a, oc_trip_a}),
    .dout ({sup_s, cmp_s, uv_s, ov_s, oc_s})
  );

  ssf_tick_timer #(.LIMIT(OCSET_TICKS)) u_ocset (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (st != ST_OCSET),
    .adv  (osc_tick && (st == ST_OCSET)),
    .done (timer_done)
  );

  ssf_ramp #(.STEPS(STEPS), .SPAN(RAMP_TICKS)) u_ramp (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  ((st != ST_SOFT) || restart),
    .adv  (osc_tick && (st == ST_SOFT)),
    .step (step),
    .last (ramp_last)
  );

  assign oc_evt = oc_s && !oc_prev;

  always_comb begin
    st_nx      = st;
    oc_seen_nx = oc_seen;
    restart    = 1'b0;
    if (!sup_s || !cmp_s) begin
      st_nx      = ST_IDLE;
      oc_seen_nx = 1'b0;
    end else begin
      case (st)
        ST_IDLE:  st_nx = ST_OCSET;
        ST_OCSET: if (timer_done) st_nx = ST_SOFT;
        ST_SOFT: begin
          if (oc_evt) begin
            if (oc_seen) st_nx = ST_LATCH;
            else begin
              oc_seen_nx = 1'b1;
              restart    = 1'b1;
            end
          end else if (ramp_last) st_nx = ST_RUN;
        end
        ST_RUN, ST_OVCLAMP: begin
          if (uv_s) st_nx = ST_LATCH;
          else if (oc_evt) begin
            oc_seen_nx = 1'b1;
            st_nx      = oc_seen ? ST_LATCH : ST_SOFT;
          end else if (st == ST_RUN && ov_s) st_nx = ST_OVCLAMP;
          else if (st == ST_OVCLAMP && !ov_s) st_nx = ST_RUN;
        end
        ST_LATCH: st_nx = ST_LATCH;
        default:  st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      oc_seen <= 1'b0;
      oc_prev <= 1'b0;
    end else begin
      st      <= st_nx;
      oc_seen <= oc_seen_nx;
      oc_prev <= oc_s;
    end
  end

  assign oc_sample     = (st == ST_OCSET);
  assign conv_en       = (st == ST_SOFT) || (st == ST_RUN);
  assign fault_latched = (st == ST_LATCH);
  assign force_low     = (st == ST_OVCLAMP);
  assign ref_code      = (st == ST_RUN || st == ST_OVCLAMP) ? FULL :
                         (st == ST_SOFT) ? step : '0;

  // R9: losing supply or enable always lands in idle
  a_r9_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_s || !cmp_s) |=> (st == ST_IDLE));
  // R6: latch holds while supply and enable stay good
  a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LATCH && sup_s && cmp_s) |=> fault_latched);
  // R7: under-voltage in regulation latches
  a_r7_uv_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && uv_s && sup_s && cmp_s) |=> (fault_latched && !conv_en));
  // R5: first over-current in regulation restarts at code 0
  a_r5_first_oc_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && oc_evt && !oc_seen && !uv_s && sup_s && cmp_s)
      |=> (conv_en && ref_code == '0 && !oc_sample));
  // R8: over-voltage in regulation clamps
  a_r8_ov_clamps: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && ov_s && !uv_s && !oc_evt && sup_s && cmp_s)
      |=> (force_low && !conv_en && ref_code == FULL));
  // R3: soft-start code climbs by at most one per cycle
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SOFT && $past(st) == ST_SOFT && !$past(restart))
      |-> (ref_code == $past(ref_code) || ref_code == $past(ref_code) + 1'b1));
endmodule

// File: tb/ssf_sequencer_tb.sv
module ssf_sequencer_tb;
  localparam int STEPS = 40;
  localparam int RAMP  = 512;
  localparam int OCSET = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic sup = 1'b0, cmp = 1'b0, uv = 1'b0, ov = 1'b0, oc = 1'b0;
  logic [5:0] ref_code;
  logic smp, en, flt, flow;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  ssf_sequencer #(.STEPS(STEPS), .RAMP_TICKS(RAMP), .OCSET_TICKS(OCSET)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(tick),
    .supply_ok_a(sup), .comp_en_a(cmp), .fb_uv_a(uv), .fb_ov_a(ov), .oc_trip_a(oc),
    .ref_code(ref_code), .oc_sample(smp), .conv_en(en),
    .fault_latched(flt), .force_low(flow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_n(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // row: sup comp uv ov oc | wait | en smp flt flow | ref
  localparam int NV = 18;
  localparam logic [26:0] VEC [NV] = '{
    {5'b11000, 12'd10,  4'b0100, 6'd0},   // R2 threshold phase
    {5'b11000, 12'd700, 4'b1000, 6'd40},  // R3 R4 regulation
    {5'b11010, 12'd5,   4'b0001, 6'd40},  // R8 clamp
    {5'b11000, 12'd5,   4'b1000, 6'd40},  // R8 release
    {5'b11001, 12'd5,   4'b1000, 6'd0},   // R5 first over-current
    {5'b11000, 12'd600, 4'b1000, 6'd40},  // R5 ramp completes again
    {5'b11001, 12'd5,   4'b0010, 6'd0},   // R6 second over-current
    {5'b11000, 12'd5,   4'b0010, 6'd0},   // R6 stays latched
    {5'b10000, 12'd5,   4'b0000, 6'd0},   // R9 enable low clears
    {5'b11000, 12'd10,  4'b0100, 6'd0},   // R9 threshold phase again
    {5'b11000, 12'd700, 4'b1000, 6'd40},  // R4 regulation
    {5'b11100, 12'd5,   4'b0010, 6'd0},   // R7 under-voltage latch
    {5'b11000, 12'd5,   4'b0010, 6'd0},   // R7 stays latched
    {5'b01000, 12'd5,   4'b0000, 6'd0},   // R9 supply loss clears
    {5'b11000, 12'd700, 4'b1000, 6'd40},  // R9 restart to regulation
    {5'b11001, 12'd5,   4'b1000, 6'd0},   // R9 count cleared: restart only
    {5'b11110, 12'd10,  4'b1000, 6'd0},   // R7 uv/ov ignored in soft-start
    {5'b11000, 12'd600, 4'b1000, 6'd40}   // R3 back to regulation
  };

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int ocs_cnt, ss_cnt, mid_code, prev_code, frozen;
    sup = 1'b1;
    cmp = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk("R1 ref", ref_code, 0);
    chk("R1 flags", {en, smp, flt, flow}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first cycle", {en, smp, flt, flow, ref_code}, 0);

    for (int i = 0; i < NV; i++) begin
      {sup, cmp, uv, ov, oc} = VEC[i][26:22];
      step_n(int'(VEC[i][21:10]));
      chk($sformatf("R%0d flags row %0d", (i < 2) ? 2 : 4, i), {en, smp, flt, flow}, int'(VEC[i][9:6]));
      chk($sformatf("R3 ref row %0d", i), ref_code, int'(VEC[i][5:0]));
    end
    uv = 1'b0; ov = 1'b0; oc = 1'b0;

    // R2 R3: exact phase lengths and ramp shape
    cmp = 1'b0;
    step_n(5);
    cmp = 1'b1;
    ocs_cnt = 0; ss_cnt = 0; mid_code = -1; prev_code = 0;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (smp) ocs_cnt++;
      if (en && ref_code != 6'(STEPS)) begin
        if (ref_code != 6'((STEPS * ss_cnt) / RAMP))
          chk($sformatf("R3 code at tick %0d", ss_cnt), ref_code, (STEPS * ss_cnt) / RAMP);
        if (ss_cnt == 256) mid_code = ref_code;
        ss_cnt++;
      end
      if (int'(ref_code) > prev_code + 1) chk("R3 jump", ref_code, prev_code + 1);
      prev_code = ref_code;
    end
    chk("R2 threshold ticks", ocs_cnt, OCSET);
    chk("R3 ramp ticks", ss_cnt, RAMP);
    chk("R3 mid code", mid_code, 20);
    chk("R3 final code", ref_code, STEPS);

    // R3: no tick, no progress
    cmp = 1'b0;
    step_n(5);
    cmp = 1'b1;
    while (!en) @(negedge clk);
    step_n(300);
    tick = 1'b0;
    frozen = ref_code;
    step_n(40);
    chk("R3 frozen code", ref_code, frozen);
    chk("R4 still enabled", en, 1);
    tick = 1'b1;
    step_n(600);
    chk("R3 resumed to full", ref_code, STEPS);

    // R10: three-edge latency
    ov = 1'b1;
    step_n(2);
    chk("R10 after two edges", flow, 0);
    step_n(1);
    chk("R10 after three edges", flow, 1);
    ov = 1'b0;
    step_n(5);
    chk("R8 released", en, 1);

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", {en, smp, flt, flow, ref_code}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule